// File: doc/BRIEF.md
# Unlock-sequence mode command decoder

This block sits on the write port of a byte-wide nonvolatile page memory model. It sees every write cycle: a 15-bit address and an 8-bit data byte, taken on the rising edge of a write strobe. It looks for a fixed six-write unlock pattern. The last write of that pattern chooses between two mode changes. One turns off the automatic clear that normally runs before a page is programmed. The other turns it back on. The chosen mode holds until the other pattern completes, a power-down is signalled, or reset is applied.

Writes that match the next expected step of the pattern are consumed. Any other write sends the matcher back to the first step and is passed on to the page buffer interface as an ordinary page byte. Forwarded bytes fill a page window of up to a set number of bytes. The window closes when it is full or when no byte arrives for a set number of cycles. Closing the window starts a busy interval whose length depends on the autoclear mode. While busy, every write is ignored. A clear-done input marks the array as blank (all ones) until the next page is committed.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, autoclr_en_o is 1 and busy_o, blank_o, pg_we_o and seq_ok_o are 0.
- R2: The writes (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), (5555h,40h) in that order make autoclr_en_o 0. In the cycle after the sixth write's strobe edge, seq_ok_o is high for exactly one cycle.
- R3: The same five leading writes followed by (5555h,50h) make autoclr_en_o 1, with the same one-cycle seq_ok_o pulse.
- R4: A write that matches the expected step is not forwarded. A write that does not match returns the matcher to the first step. That write appears on pg_we_o/pg_addr_o/pg_data_o in the cycle after its strobe edge.
- R5: A sixth write whose data is neither 40h nor 50h, or whose address is not 5555h, leaves autoclr_en_o unchanged, gives no seq_ok_o pulse, and is forwarded.
- R6: Forwarded bytes are counted into a page of PAGE_BYTES bytes. busy_o rises in the cycle after the strobe edge of the last byte of the page.
- R7: The busy interval lasts PROG_CYC cycles if autoclear is off when the page commits. It lasts ERASE_CYC+PROG_CYC cycles if autoclear is on.
- R8: A partly filled page commits WIN_CYC cycles after the strobe edge of its last byte, if no further byte arrives.
- R9: While busy_o is 1, writes are ignored: nothing is forwarded, no seq_ok_o pulse occurs, and the mode does not change.
- R10: A one-cycle pwr_down_i sets autoclr_en_o to 1 and clears busy_o. It also returns the matcher to the first step.
- R11: A clr_done_i pulse sets blank_o to 1. blank_o returns to 0 at the edge where the next page commits.
- R12: A strobe held high across several clocks produces one write event only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_down_i | input | 1 | Power-down event; restores default mode |
| wr_stb_i | input | 1 | Write strobe; sampled rising edge marks one write |
| wr_addr_i | input | 15 | Write address |
| wr_data_i | input | 8 | Write data |
| clr_done_i | input | 1 | Chip clear finished pulse |
| autoclr_en_o | output | 1 | Clear-before-write enabled |
| seq_ok_o | output | 1 | One-cycle pulse when an unlock pattern is accepted |
| pg_we_o | output | 1 | Forwarded page byte valid |
| pg_addr_o | output | 15 | Forwarded page byte address |
| pg_data_o | output | 8 | Forwarded page byte data |
| busy_o | output | 1 | Programming interval in progress |
| blank_o | output | 1 | Array reads all ones after a chip clear |

## Verification
The bench builds the block with PAGE_BYTES=4, WIN_CYC=8, PROG_CYC=20 and ERASE_CYC=30. With these values a full page closes after four writes and an idle window is eight cycles long. Both busy lengths can therefore be counted cycle by cycle in a few dozen clocks. A whole six-write pattern still fits inside the short busy interval, so a pattern can be issued during busy to show it is ignored.

// File: rtl/unlock_cmd_pkg.sv
package unlock_cmd_pkg;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int STEPS = 6;
  localparam int SW = $clog2(STEPS);

  localparam logic [AW-1:0] ADDR_HI = 15'h5555;
  localparam logic [AW-1:0] ADDR_LO = 15'h2AAA;
  localparam logic [DW-1:0] CODE_OFF = 8'h40;
  localparam logic [DW-1:0] CODE_ON  = 8'h50;
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  typedef logic [SW-1:0] step_t;

  function automatic logic [AW-1:0] step_addr(input step_t s);
    case (s)
      3'd1, 3'd4: step_addr = ADDR_LO;
      default:    step_addr = ADDR_HI;
    endcase
  endfunction

  function automatic logic [DW-1:0] step_data(input step_t s);
    case (s)
      3'd0, 3'd3: step_data = 8'hAA;
      3'd1, 3'd4: step_data = 8'h55;
      3'd2:       step_data = 8'h80;
      default:    step_data = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/unlock_matcher.sv
module unlock_matcher
  import unlock_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_down_i,
  input  logic          evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          pass_o,
  output logic          autoclr_o,
  output logic          accept_o
);
  step_t step_q;
  logic  autoclr_q, accept_q;
  logic  is_last, hit;

  assign is_last = (step_q == LAST_STEP);

  always_comb begin
    if (is_last)
      hit = (addr_i == ADDR_HI) && (data_i == CODE_OFF || data_i == CODE_ON);
    else
      hit = (addr_i == step_addr(step_q)) && (data_i == step_data(step_q));
  end

  assign pass_o = evt_i & ~hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= '0;
      autoclr_q <= 1'b1;
      accept_q  <= 1'b0;
    end else if (pwr_down_i) begin
      step_q    <= '0;
      autoclr_q <= 1'b1;
      accept_q  <= 1'b0;
    end else begin
      accept_q <= 1'b0;
      if (evt_i) begin
        if (!hit) begin
          step_q <= '0;
        end else if (is_last) begin
          step_q    <= '0;
          autoclr_q <= (data_i == CODE_ON);
          accept_q  <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign autoclr_o = autoclr_q;
  assign accept_o  = accept_q;

  a_r10_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST_STEP);
  a_r2_mode_change_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(autoclr_q) |-> (accept_q || $past(pwr_down_i)));
endmodule

// File: rtl/page_window.sv
module page_window #(
  parameter int PAGE_BYTES = 64,
  parameter int WIN_CYC    = 150,
  parameter int PROG_CYC   = 5000,
  parameter int ERASE_CYC  = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_down_i,
  input  logic byte_i,
  input  logic autoclr_i,
  output logic commit_o,
  output logic busy_o
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam int IW = $clog2(WIN_CYC + 1);
  localparam int BW = $clog2(ERASE_CYC + PROG_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PAGE_BYTES - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(WIN_CYC - 1);
  localparam logic [BW-1:0] LOAD_SHORT = BW'(PROG_CYC);
  localparam logic [BW-1:0] LOAD_LONG  = BW'(ERASE_CYC + PROG_CYC);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idle_q;
  logic [BW-1:0] busy_q;
  logic          full_hit, timeout, commit;

  assign full_hit = byte_i && (cnt_q == CNT_LAST);
  assign timeout  = !byte_i && (cnt_q != '0) && (idle_q == IDLE_LAST);
  assign commit   = full_hit | timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= '0;
      busy_q <= '0;
    end else if (pwr_down_i) begin
      cnt_q  <= '0;
      idle_q <= '0;
      busy_q <= '0;
    end else begin
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (commit) begin
        cnt_q  <= '0;
        idle_q <= '0;
        busy_q <= autoclr_i ? LOAD_LONG : LOAD_SHORT;
      end else if (byte_i) begin
        cnt_q  <= cnt_q + 1'b1;
        idle_q <= '0;
      end else if (cnt_q != '0) begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign commit_o = commit;
  assign busy_o   = (busy_q != '0);

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PAGE_BYTES));
  a_r8_idle_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q < IW'(WIN_CYC));
  a_r9_no_byte_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !byte_i);
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import unlock_cmd_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int WIN_CYC    = 150,
  parameter int PROG_CYC   = 5000,
  parameter int ERASE_CYC  = 15000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_down_i,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_done_i,
  output logic          autoclr_en_o,
  output logic          seq_ok_o,
  output logic          pg_we_o,
  output logic [AW-1:0] pg_addr_o,
  output logic [DW-1:0] pg_data_o,
  output logic          busy_o,
  output logic          blank_o
);
  logic          stb_q, evt, pass, autoclr, accept, commit, busy;
  logic          pg_we_q, blank_q;
  logic [AW-1:0] pg_addr_q;
  logic [DW-1:0] pg_data_q;

  // one event per strobe rise; swallowed entirely while programming
  assign evt = wr_stb_i & ~stb_q & ~busy;

  unlock_matcher u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_down_i (pwr_down_i),
    .evt_i      (evt),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .pass_o     (pass),
    .autoclr_o  (autoclr),
    .accept_o   (accept)
  );

  page_window #(
    .PAGE_BYTES (PAGE_BYTES),
    .WIN_CYC    (WIN_CYC),
    .PROG_CYC   (PROG_CYC),
    .ERASE_CYC  (ERASE_CYC)
  ) u_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_down_i (pwr_down_i),
    .byte_i     (pass),
    .autoclr_i  (autoclr),
    .commit_o   (commit),
    .busy_o     (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q     <= 1'b0;
      pg_we_q   <= 1'b0;
      pg_addr_q <= '0;
      pg_data_q <= '0;
      blank_q   <= 1'b0;
    end else begin
      stb_q   <= wr_stb_i;
      pg_we_q <= pass && !pwr_down_i;
      if (pass) begin
        pg_addr_q <= wr_addr_i;
        pg_data_q <= wr_data_i;
      end
      if (pwr_down_i)      blank_q <= 1'b0;
      else if (clr_done_i) blank_q <= 1'b1;
      else if (commit)     blank_q <= 1'b0;
    end
  end

  assign autoclr_en_o = autoclr;
  assign seq_ok_o     = accept;
  assign pg_we_o      = pg_we_q;
  assign pg_addr_o    = pg_addr_q;
  assign pg_data_o    = pg_data_q;
  assign busy_o       = busy;
  assign blank_o      = blank_q;

  a_r9_busy_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !pg_we_o);
  a_r2_seq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_ok_o |=> !seq_ok_o);
  a_r4_fwd_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_o |-> !seq_ok_o);
  a_r11_blank_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blank_o) |-> (busy_o || $past(pwr_down_i)));
endmodule

// File: tb/unlock_cmd_decoder_test.sv
module unlock_cmd_decoder_test;
  localparam int PB  = 4;
  localparam int WIN = 8;
  localparam int PRG = 20;
  localparam int ERS = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_down = 1'b0;
  logic        stb = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic        clr_done = 1'b0;
  logic        autoclr_en, seq_ok, pg_we, busy, blank;
  logic [14:0] pg_addr;
  logic [7:0]  pg_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  unlock_cmd_decoder #(
    .PAGE_BYTES (PB), .WIN_CYC (WIN), .PROG_CYC (PRG), .ERASE_CYC (ERS)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .pwr_down_i (pwr_down),
    .wr_stb_i (stb), .wr_addr_i (addr), .wr_data_i (data),
    .clr_done_i (clr_done), .autoclr_en_o (autoclr_en), .seq_ok_o (seq_ok),
    .pg_we_o (pg_we), .pg_addr_o (pg_addr), .pg_data_o (pg_data),
    .busy_o (busy), .blank_o (blank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic settle();
    repeat (WIN + 1) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_pd();
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk); pwr_down = 1'b0;
  endtask

  task automatic run_seq(input logic [7:0] last, input string req);
    wr(15'h5555, 8'hAA); chk({req, " step1 not forwarded"}, pg_we, 0);
    wr(15'h2AAA, 8'h55); chk({req, " step2 not forwarded"}, pg_we, 0);
    wr(15'h5555, 8'h80); chk({req, " step3 not forwarded"}, pg_we, 0);
    wr(15'h5555, 8'hAA); chk({req, " step4 not forwarded"}, pg_we, 0);
    wr(15'h2AAA, 8'h55); chk({req, " step5 not forwarded"}, pg_we, 0);
    wr(15'h5555, last);
  endtask

  task automatic t_reset();
    chk("R1 autoclr", autoclr_en, 1);
    chk("R1 busy", busy, 0);
    chk("R1 blank", blank, 0);
    chk("R1 pg_we", pg_we, 0);
    chk("R1 seq_ok", seq_ok, 0);
  endtask

  task automatic t_disable();
    run_seq(8'h40, "R2");
    chk("R2 seq_ok pulse", seq_ok, 1);
    chk("R2 autoclr off", autoclr_en, 0);
    chk("R2 sixth not forwarded", pg_we, 0);
    @(negedge clk);
    chk("R2 pulse one cycle", seq_ok, 0);
  endtask

  task automatic t_page_full();
    int n = 0;
    for (int i = 0; i < PB; i++) begin
      wr(15'h0100 + 15'(i), 8'h10 + 8'(i));
      chk("R6 forwarded we", pg_we, 1);
      chk("R6 forwarded addr", pg_addr, 32'(15'h0100 + 15'(i)));
      chk("R6 forwarded data", pg_data, 32'(8'h10 + 8'(i)));
      chk("R6 busy at byte", busy, (i == PB - 1) ? 1 : 0);
    end
    while (busy) begin n++; @(negedge clk); end
    chk("R7 busy length autoclear off", n, PRG);
  endtask

  task automatic t_enable();
    run_seq(8'h50, "R3");
    chk("R3 seq_ok pulse", seq_ok, 1);
    chk("R3 autoclr on", autoclr_en, 1);
  endtask

  task automatic t_idle_commit();
    int w = 0;
    int n = 0;
    wr(15'h0200, 8'h33);
    while (!busy && w < 100) begin w++; @(negedge clk); end
    chk("R8 idle window", w, WIN);
    while (busy) begin n++; @(negedge clk); end
    chk("R7 busy length autoclear on", n, PRG + ERS);
  endtask

  task automatic t_mismatch();
    wr(15'h5555, 8'hAA); chk("R4 match consumed", pg_we, 0);
    wr(15'h2AAA, 8'h55); chk("R4 match consumed", pg_we, 0);
    wr(15'h5555, 8'hAA);
    chk("R4 mismatch forwarded", pg_we, 1);
    chk("R4 mismatch addr", pg_addr, 32'h5555);
    chk("R4 mismatch data", pg_data, 32'hAA);
    settle();
    run_seq(8'h40, "R4 restart");
    chk("R4 matcher restarted at step1", autoclr_en, 0);
  endtask

  task automatic t_bad_sixth();
    run_seq(8'h60, "R5");
    chk("R5 no pulse", seq_ok, 0);
    chk("R5 forwarded", pg_we, 1);
    chk("R5 mode kept", autoclr_en, 0);
    settle();
    run_seq(8'h50, "R5 addr");
    run_seq(8'h50, "R5 addr");
    chk("R5 mode on", autoclr_en, 1);
    run_seq(8'h40, "R5 addr");
    chk("R5 mode off", autoclr_en, 0);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h2AAA, 8'h50);
    chk("R5 wrong sixth addr forwarded", pg_we, 1);
    chk("R5 wrong sixth addr mode kept", autoclr_en, 0);
    settle();
  endtask

  task automatic t_busy_ignore();
    wr(15'h0300, 8'h77);
    while (!busy) @(negedge clk);
    run_seq(8'h50, "R9");
    chk("R9 no pulse while busy", seq_ok, 0);
    chk("R9 mode kept while busy", autoclr_en, 0);
    chk("R9 still busy", busy, 1);
    settle();
  endtask

  task automatic t_pwrdown();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
    pulse_pd();
    chk("R10 autoclr restored", autoclr_en, 1);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h40);
    chk("R10 matcher reset, write forwarded", pg_we, 1);
    chk("R10 mode unchanged", autoclr_en, 1);
    wr(15'h0400, 8'h01);
    while (!busy) @(negedge clk);
    pulse_pd();
    chk("R10 busy cleared", busy, 0);
    settle();
  endtask

  task automatic t_blank();
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
    chk("R11 blank set", blank, 1);
    wr(15'h0500, 8'h5A);
    chk("R11 blank held before commit", blank, 1);
    while (!busy) @(negedge clk);
    chk("R11 blank cleared at commit", blank, 0);
    settle();
  endtask

  task automatic t_hold();
    @(negedge clk);
    addr = 15'h0600; data = 8'hC3; stb = 1'b1;
    @(negedge clk);
    chk("R12 first event", pg_we, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 no repeat while held", pg_we, 0);
    end
    stb = 1'b0;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_page_full();
    t_enable();
    t_idle_commit();
    t_mismatch();
    t_bad_sixth();
    t_busy_ignore();
    t_pwrdown();
    t_blank();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule